// File: doc/BRIEF.md
# Stochastic binary neuron

This block turns a signed fixed-point drive value into a random bit whose chance of being 1 rises with the drive along a tanh-like curve. The bit is a sample, not a threshold. It is built from three parts. A 16-bit linear-feedback shift register supplies the random word. A 64-entry activation table maps the saturated upper bits of the drive to a 16-bit unsigned level. A magnitude compare sets the output bit when the level is above the random word.

A surrounding network recomputes each neuron's drive from its neighbours' bits and strobes the update enable. One cycle after each accepted strobe the block presents a new sample together with a one-cycle valid pulse. A seed-load port lets the system give each neuron its own pseudo-random sequence.

Top module: `pbit_top`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, that edge clears `sampleBit` and `sampleValid` and sets the random register to the `RESET_SEED` value (default 16'hACE1).
- R2: The random register holds 16 bits, never holds zero, and moves one step per accepted update. A step gives the next state {s[14:0], s[15]^s[13]^s[12]^s[10]}. With no accepted update and no seed load, the register holds its value.
- R3: When `seedLoad` is high at an edge, the random register takes `seedValue`, or 16'h0001 if `seedValue` is zero. Seed load wins over an update in the same cycle: that update is dropped and produces no valid pulse.
- R4: The activation level A is computed from k = drive >>> 8 (arithmetic shift), with k clamped to [-32, 31]. A = 32768 + (32767*k)/(|k|+2), where the division truncates toward zero. A drive of zero gives A = 16'h8000.
- R5: An accepted update (`updateEn` high, `seedLoad` low, outside reset) at edge t steps the register to R'. At edge t, `sampleBit` becomes (A > R'), compared unsigned, and `sampleValid` is high for exactly the cycle after edge t.
- R6: `sampleBit` holds its value in every cycle that has no accepted update. `sampleValid` is low in those cycles.
- R7: A drive beyond the table range gives the same level as the nearest end entry. For example, drive 16'sh7FFF behaves as k = 31 and drive -16'sh8000 behaves as k = -32.
- R8: With drive zero, between 40% and 60% of 1000 consecutive samples are 1.
- R9: At drive 16'sh7FFF at least 90% of samples are 1. At drive -16'sh8000 at most 10% are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seedLoad | input | 1 | Load `seedValue` into the random register |
| seedValue | input | 16 | Seed word; zero is replaced by 1 |
| updateEn | input | 1 | Request one new sample |
| drive | input | 16 | Signed input value |
| sampleBit | output | 1 | Registered random output bit |
| sampleValid | output | 1 | One-cycle pulse marking a new sample |

## Verification
A reference model in the bench tracks the random sequence and predicts every sample exactly. It is exercised with four input patterns. A sweep across the table, including its steps near zero, separates a correct curve from one that is shifted or mis-indexed. Drives far past both ends show whether the clamp works. Long runs at zero and at each extreme test the sample statistics. Seed loads are issued alone, with a zero seed, and together with an update. These show whether the zero-seed fix-up and the load-over-update priority hold. Idle gaps between updates show whether the output holds and whether a valid pulse appears where none should.

// File: rtl/pbit_pkg.sv
package pbit_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic clear;     // synchronous reset
    logic loadSeed;  // replace random state with seed
    logic step;      // advance random state and take a sample
  } pbitStrobe_t;
endpackage

// File: rtl/pbit_ctrl.sv
module pbit_ctrl
  import pbit_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        seedLoad,
  input  logic        updateEn,
  output pbitStrobe_t strobe,
  output logic        sampleValid
);
  // Priority: reset, then seed load, then update
  always_comb begin
    strobe.clear    = rst;
    strobe.loadSeed = !rst && seedLoad;
    strobe.step     = !rst && !seedLoad && updateEn;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) sampleValid <= 1'b0;
    else              sampleValid <= strobe.step;
  end
endmodule

// File: rtl/pbit_datapath.sv
module pbit_datapath
  import pbit_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int RND_W  = 16,
  parameter int ADDR_W = 6,
  parameter int SHIFT  = 8,
  parameter logic [RND_W-1:0] TAP_MASK   = 16'hB400,
  parameter logic [RND_W-1:0] RESET_SEED = 16'hACE1
) (
  input  logic                   clk,
  input  pbitStrobe_t            strobe,
  input  logic [RND_W-1:0]       seedValue,
  input  logic signed [IN_W-1:0] drive,
  output logic [RND_W-1:0]       rndWord,
  output logic                   sampleBit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;
  localparam int MID   = 1 << (RND_W - 1);
  localparam logic signed [IN_W-1:0] K_MAX = IN_W'(HALF - 1);
  localparam logic signed [IN_W-1:0] K_MIN = IN_W'(-HALF);

  // Soft-sign curve: monotonic, centred at MID, saturating toward both rails
  function automatic logic [RND_W-1:0] actEntry(input int k);
    int mag;
    int lvl;
    mag = (k < 0) ? -k : k;
    lvl = MID + ((MID - 1) * k) / (mag + 2);
    return RND_W'(lvl);
  endfunction

  logic [RND_W-1:0] actLut [DEPTH];
  for (genvar i = 0; i < DEPTH; i++) begin : g_lut
    assign actLut[i] = actEntry(i - HALF);
  end

  // Saturating address from the upper bits of the drive
  logic signed [IN_W-1:0] scaled;
  logic [ADDR_W-1:0]      lutAddr;
  logic [RND_W-1:0]       actLevel;
  assign scaled = drive >>> SHIFT;
  always_comb begin
    if (scaled > K_MAX)      lutAddr = '1;
    else if (scaled < K_MIN) lutAddr = '0;
    else                     lutAddr = {~scaled[ADDR_W-1], scaled[ADDR_W-2:0]};
  end
  assign actLevel = actLut[lutAddr];

  // Fibonacci shift register
  logic [RND_W-1:0] lfsrQ, lfsrNext;
  assign lfsrNext = {lfsrQ[RND_W-2:0], ^(lfsrQ & TAP_MASK)};

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      lfsrQ     <= RESET_SEED;
      sampleBit <= 1'b0;
    end else if (strobe.loadSeed) begin
      lfsrQ <= (seedValue == '0) ? RND_W'(1) : seedValue;
    end else if (strobe.step) begin
      lfsrQ     <= lfsrNext;
      sampleBit <= (actLevel > lfsrNext);
    end
  end

  assign rndWord = lfsrQ;
endmodule

// File: rtl/pbit_top.sv
module pbit_top
  import pbit_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int RND_W  = 16,
  parameter int ADDR_W = 6,
  parameter int SHIFT  = 8,
  parameter logic [RND_W-1:0] TAP_MASK   = 16'hB400,
  parameter logic [RND_W-1:0] RESET_SEED = 16'hACE1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   seedLoad,
  input  logic [RND_W-1:0]       seedValue,
  input  logic                   updateEn,
  input  logic signed [IN_W-1:0] drive,
  output logic                   sampleBit,
  output logic                   sampleValid
);
  pbitStrobe_t      strobe;
  logic [RND_W-1:0] rndWord;

  pbit_ctrl u_ctrl (
    .clk(clk), .rst(rst), .seedLoad(seedLoad), .updateEn(updateEn),
    .strobe(strobe), .sampleValid(sampleValid)
  );

  pbit_datapath #(
    .IN_W(IN_W), .RND_W(RND_W), .ADDR_W(ADDR_W), .SHIFT(SHIFT),
    .TAP_MASK(TAP_MASK), .RESET_SEED(RESET_SEED)
  ) u_dp (
    .clk(clk), .strobe(strobe), .seedValue(seedValue), .drive(drive),
    .rndWord(rndWord), .sampleBit(sampleBit)
  );
endmodule

// File: rtl/pbit_checker.sv
module pbit_checker #(
  parameter int RND_W = 16,
  parameter logic [RND_W-1:0] RESET_SEED = 16'hACE1
) (
  input logic             clk,
  input logic             rst,
  input logic             seedLoad,
  input logic [RND_W-1:0] seedValue,
  input logic             updateEn,
  input logic             sampleBit,
  input logic             sampleValid,
  input logic [RND_W-1:0] rndWord
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (rndWord == RESET_SEED && !sampleValid && !sampleBit));

  assert_never_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (rndWord != '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!updateEn && !seedLoad) |=> $stable(rndWord));

  assert_seed_load_R3: assert property (@(posedge clk) disable iff (rst)
    seedLoad |=> (rndWord == (($past(seedValue) == '0) ? RND_W'(1) : $past(seedValue))));

  assert_seed_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && updateEn) |=> !sampleValid);

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (updateEn && !seedLoad) |=> sampleValid);

  assert_bit_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(updateEn && !seedLoad) |=> ($stable(sampleBit) && !sampleValid));
endmodule

bind pbit_top pbit_checker #(.RND_W(RND_W), .RESET_SEED(RESET_SEED)) chk (
  .clk(clk), .rst(rst), .seedLoad(seedLoad), .seedValue(seedValue),
  .updateEn(updateEn), .sampleBit(sampleBit), .sampleValid(sampleValid),
  .rndWord(rndWord)
);

// File: tb/pbit_top_test.sv
`timescale 1ns/1ps
module pbit_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seedLoad = 1'b0;
  logic [15:0] seedValue = '0;
  logic updateEn = 1'b0;
  logic signed [15:0] drive = '0;
  logic sampleBit, sampleValid;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  pbit_top uut (
    .clk(clk), .rst(rst), .seedLoad(seedLoad), .seedValue(seedValue),
    .updateEn(updateEn), .drive(drive), .sampleBit(sampleBit),
    .sampleValid(sampleValid)
  );

  // Reference model state
  logic [15:0] model = 16'hACE1;
  typedef struct { logic bitv; string req; } item_t;
  item_t q[$];
  logic lastBit = 1'b0;
  int ones = 0;

  function automatic logic [15:0] stepOf(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic int levelOf(logic signed [15:0] d);
    int k, mag;
    k = int'(d) >>> 8;
    if (k > 31) k = 31;
    if (k < -32) k = -32;
    mag = (k < 0) ? -k : k;
    return 32768 + (32767 * k) / (mag + 2);
  endfunction

  task automatic record(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Driver: one accepted update, expected bit pushed to the scoreboard
  task automatic doUpdate(input logic signed [15:0] d, input string req);
    item_t it;
    model = stepOf(model);
    it.bitv = (levelOf(d) > int'(model));
    it.req  = req;
    q.push_back(it);
    drive    = d;
    updateEn = 1'b1;
    @(negedge clk);
    updateEn = 1'b0;
  endtask

  task automatic doSeed(input logic [15:0] s, input bit withUpdate);
    seedValue = s;
    seedLoad  = 1'b1;
    updateEn  = withUpdate;
    model     = (s == 16'h0) ? 16'h0001 : s;
    @(negedge clk);
    seedLoad = 1'b0;
    updateEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compares each valid sample, flags stray pulses
  always @(negedge clk) begin
    if (!rst && sampleValid) begin
      if (q.size() == 0) begin
        record(1'b0, "R3/R6", "valid pulse with no accepted update (actual 1, expected 0)");
      end else begin
        item_t it;
        it = q.pop_front();
        record(sampleBit === it.bitv, it.req,
               $sformatf("sample actual %0b expected %0b", sampleBit, it.bitv));
        lastBit = it.bitv;
        if (sampleBit) ones++;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    record(sampleBit === 1'b0 && sampleValid === 1'b0, "R1",
           $sformatf("reset outputs actual %0b/%0b expected 0/0", sampleBit, sampleValid));
    // R1, R2, R5: first samples follow the reset seed
    doUpdate(16'sh0000, "R1");
    doUpdate(16'sh0000, "R2");
    idle(1);
    // R4: sweep across the table, including near zero
    for (int d = -9000; d <= 9000; d += 180) doUpdate(16'(d), "R4");
    for (int d = -600; d <= 600; d += 1) doUpdate(16'(d), "R4");
    idle(2);
    // R6: output holds during an idle stretch
    idle(5);
    record(sampleBit === lastBit && sampleValid === 1'b0, "R6",
           $sformatf("idle output actual %0b expected %0b", sampleBit, lastBit));
    // R3: plain seed, zero seed, seed colliding with update
    doSeed(16'h1234, 1'b0);
    for (int i = 0; i < 40; i++) doUpdate(16'(i * 150 - 3000), "R3");
    doSeed(16'h0000, 1'b0);
    for (int i = 0; i < 40; i++) doUpdate(16'sh0080, "R3");
    doSeed(16'hBEEF, 1'b1);
    idle(2);
    record(q.size() == 0, "R3", $sformatf("pending items actual %0d expected 0", q.size()));
    for (int i = 0; i < 40; i++) doUpdate(16'(i * 400 - 8000), "R3");
    // R7: drives beyond the table ends
    for (int i = 0; i < 30; i++) doUpdate(16'sh7FFF - 16'(i * 37), "R7");
    for (int i = 0; i < 30; i++) doUpdate(-16'sh8000 + 16'(i * 41), "R7");
    idle(2);
    // R8: zero drive statistics
    ones = 0;
    for (int i = 0; i < 1000; i++) doUpdate(16'sh0000, "R8");
    idle(2);
    record(ones >= 400 && ones <= 600, "R8",
           $sformatf("ones at zero actual %0d expected 400..600", ones));
    // R9: extremes
    ones = 0;
    for (int i = 0; i < 500; i++) doUpdate(16'sh7FFF, "R9");
    idle(2);
    record(ones >= 450, "R9", $sformatf("ones at max actual %0d expected >=450", ones));
    ones = 0;
    for (int i = 0; i < 500; i++) doUpdate(-16'sh8000, "R9");
    idle(2);
    record(ones <= 50, "R9", $sformatf("ones at min actual %0d expected <=50", ones));
    // R1: reset in mid-run clears outputs
    doUpdate(16'sh7FFF, "R1");
    rst = 1'b1;
    @(negedge clk);
    record(sampleBit === 1'b0 && sampleValid === 1'b0, "R1",
           $sformatf("mid-run reset actual %0b/%0b expected 0/0", sampleBit, sampleValid));
    q.delete();
    rst = 1'b0;
    model = 16'hACE1;
    for (int i = 0; i < 20; i++) doUpdate(16'(i * 500 - 5000), "R1");
    idle(2);
    record(q.size() == 0, "R5", $sformatf("unmatched items actual %0d expected 0", q.size()));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule